// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

The block connects a simple single-word request port to an external asynchronous byte-wide static RAM. It turns each accepted read or write into a correctly ordered set of strobes: an address bus, a split data bus (data out, data in and a driver enable) and active-low chip select, output enable and write enable. Every interval in the cycle is a count of system clocks. The host supplies these counts as 4-bit configuration inputs, and the block samples them when it accepts a request. A count of zero acts as one clock.

A read drives the address first, then chip select, then output enable. The block holds output enable until the address, chip-select and output-enable access times have all passed, each counted from its own start. It then captures the data, deasserts both strobes and waits out a bus-release interval. A write drives the address and chip select together. It lowers write enable after the setup count and drives data for the data-setup count before write enable rises, because that rising edge stores the byte. It keeps data driven for the hold count afterwards. Both kinds of cycle are padded with idle clocks up to a minimum cycle length. The block then gives a one-clock done pulse, with the read data valid on reads.

Top module: `sram_seq`

## Requirements
- R1: A synchronous reset, also one asserted mid-cycle, leaves cs_n, oe_n and we_n high, dout_en low, done low and req_ready high from the next clock.
- R2: A request is taken when req_valid and req_ready are both high at a clock edge. The address then appears on sram_addr in the next clock, called cycle 0. sram_addr holds it until done. req_ready stays low from cycle 0 until the done cycle, and a req_valid seen in that span is ignored.
- R3: In a read with setup count S, cs_n falls in cycle S and oe_n falls in cycle S+1.
- R4: In a read, oe_n stays low for K = max(n(toe), n(tcs)-1, n(taa)-S-1) cycles. Here n(x) is x, or 1 when x is 0. toe, tcs and taa are the output-enable, chip-select and address access counts. Data is captured at the clock edge where oe_n and cs_n rise together, and is presented on rdata.
- R5: After a read's strobes rise at cycle S+1+K, no strobe is asserted and dout_en stays low for n(release) cycles before done.
- R6: In a write, cs_n is low from cycle 0 and we_n falls in cycle S.
- R7: In a write, we_n stays low for K = max(n(we_width), n(data_setup)) cycles. cs_n rises together with we_n.
- R8: In a write, dout_en rises exactly n(data_setup) cycles before we_n rises, with sram_dout equal to the accepted write data.
- R9: In a write, dout_en stays high for n(hold) cycles after we_n rises.
- R10: done is high in cycle max(body, n(cycle_min)). body is S+1+K+n(release) for reads and S+K+n(hold) for writes.
- R11: Every timing count of zero behaves exactly like a count of one.
- R12: dout_en is never high while oe_n is low, and it is never high during a read.
- R13: done is a one-clock pulse. rdata changes only at a read capture, so it keeps its old value across a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| cfg_setup | input | CW | Address setup count |
| cfg_acc_addr | input | CW | Access time from address valid |
| cfg_acc_cs | input | CW | Access time from chip select |
| cfg_acc_oe | input | CW | Access time from output enable |
| cfg_release | input | CW | Bus release after a read |
| cfg_we_width | input | CW | Minimum write strobe width |
| cfg_data_setup | input | CW | Data valid before write strobe rises |
| cfg_data_hold | input | CW | Data held after write strobe rises |
| cfg_cycle_min | input | CW | Minimum cycle length |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| sram_addr | output | AW | RAM address bus |
| sram_dout | output | DW | Data toward the RAM |
| sram_din | input | DW | Data from the RAM |
| sram_dout_en | output | 1 | Enable for the data-out drivers |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
The reads are chosen so that the address, chip-select and output-enable access times each win in turn. This separates a correct maximum from one that ignores a term or starts the wrong count. The bench's RAM model returns a marker byte until all three times have passed, so an early capture shows up in rdata. The writes include a strobe width longer than the data setup and the reverse, all-zero counts and a long minimum cycle, which separate the strobe-width, data-window and padding rules. Requests follow each other back to back, with a stray request and scrambled counts during every cycle, so sampling at acceptance and ignoring busy requests are both exercised.

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_acc_addr,
  input  logic [CW-1:0] cfg_acc_cs,
  input  logic [CW-1:0] cfg_acc_oe,
  input  logic [CW-1:0] cfg_release,
  input  logic [CW-1:0] cfg_we_width,
  input  logic [CW-1:0] cfg_data_setup,
  input  logic [CW-1:0] cfg_data_hold,
  input  logic [CW-1:0] cfg_cycle_min,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dout,
  input  logic [DW-1:0] sram_din,
  output logic          sram_dout_en,
  output logic          sram_cs_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);
  localparam int TW = CW + 2;
  typedef logic [TW-1:0] tick_t;
  localparam tick_t ONE = tick_t'(1);

  function automatic tick_t at_least1(input logic [CW-1:0] v);
    return (v == '0) ? ONE : tick_t'(v);
  endfunction

  function automatic tick_t tmax(input tick_t a, input tick_t b);
    return (a > b) ? a : b;
  endfunction

  logic  busy, wr;
  tick_t tot, cs_on, st_on, off, d_on, d_off, fin;

  tick_t s_n, aa_n, acs_n, aoe_n, rel_n, wew_n, ds_n, hd_n, cm_n;
  tick_t k_rd, k_wr, aa_rem;
  tick_t mk_cs_on, mk_st_on, mk_off, mk_d_on, mk_d_off, mk_fin;

  always_comb begin
    s_n   = at_least1(cfg_setup);
    aa_n  = at_least1(cfg_acc_addr);
    acs_n = at_least1(cfg_acc_cs);
    aoe_n = at_least1(cfg_acc_oe);
    rel_n = at_least1(cfg_release);
    wew_n = at_least1(cfg_we_width);
    ds_n  = at_least1(cfg_data_setup);
    hd_n  = at_least1(cfg_data_hold);
    cm_n  = at_least1(cfg_cycle_min);
    aa_rem = (aa_n > s_n + ONE) ? aa_n - s_n - ONE : '0;
    k_rd   = tmax(tmax(aoe_n, acs_n - ONE), aa_rem);
    k_wr   = tmax(wew_n, ds_n);
    if (req_write) begin
      mk_cs_on = '0;
      mk_st_on = s_n;
      mk_off   = s_n + k_wr;
      mk_d_on  = mk_off - ds_n;
      mk_d_off = mk_off + hd_n;
      mk_fin   = tmax(mk_d_off, cm_n);
    end else begin
      mk_cs_on = s_n;
      mk_st_on = s_n + ONE;
      mk_off   = s_n + ONE + k_rd;
      mk_d_on  = '0;
      mk_d_off = '0;
      mk_fin   = tmax(mk_off + rel_n, cm_n);
    end
  end

  wire   accept  = req_valid && !busy;
  wire   wr_nx   = accept ? req_write : wr;
  wire   tick_t tot_nx  = accept ? '0 : tot + ONE;
  wire   live_nx = accept || (busy && tot_nx < fin);
  wire   tick_t c_cs_on = accept ? mk_cs_on : cs_on;
  wire   tick_t c_st_on = accept ? mk_st_on : st_on;
  wire   tick_t c_off   = accept ? mk_off   : off;
  wire   tick_t c_d_on  = accept ? mk_d_on  : d_on;
  wire   tick_t c_d_off = accept ? mk_d_off : d_off;
  wire   strobe_nx = live_nx && tot_nx >= c_st_on && tot_nx < c_off;

  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;  wr <= 1'b0;  tot <= '0;
      cs_on <= '0;  st_on <= '0;  off <= '0;
      d_on <= '0;  d_off <= '0;  fin <= '0;
      done <= 1'b0;  rdata <= '0;
      sram_addr <= '0;  sram_dout <= '0;  sram_dout_en <= 1'b0;
      sram_cs_n <= 1'b1;  sram_oe_n <= 1'b1;  sram_we_n <= 1'b1;
    end else begin
      busy <= live_nx;
      tot  <= live_nx ? tot_nx : '0;
      done <= busy && (tot + ONE == fin);
      if (accept) begin
        wr <= req_write;
        cs_on <= mk_cs_on;  st_on <= mk_st_on;  off <= mk_off;
        d_on <= mk_d_on;  d_off <= mk_d_off;  fin <= mk_fin;
        sram_addr <= req_addr;
        sram_dout <= req_wdata;
      end
      if (busy && !wr && tot_nx == off) rdata <= sram_din;
      sram_cs_n    <= !(live_nx && tot_nx >= c_cs_on && tot_nx < c_off);
      sram_oe_n    <= !(strobe_nx && !wr_nx);
      sram_we_n    <= !(strobe_nx && wr_nx);
      sram_dout_en <= live_nx && wr_nx && tot_nx >= c_d_on && tot_nx < c_d_off;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (sram_cs_n && sram_oe_n && sram_we_n && !sram_dout_en && !done));

  // R12
  no_drive_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(sram_dout_en && !sram_oe_n));

  // R3
  oe_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_oe_n) |-> (!sram_cs_n && $past(!sram_cs_n)));

  // R7
  we_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_cs_n);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sram_seq_tb.sv
`timescale 1ns/1ps
module sram_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic [3:0] c_setup = '0, c_aa = '0, c_acs = '0, c_aoe = '0, c_rel = '0;
  logic [3:0] c_we = '0, c_ds = '0, c_hold = '0, c_cmin = '0;
  logic req_ready, done, dout_en, cs_n, oe_n, we_n;
  logic [7:0] rdata, sram_addr, sram_dout;
  logic [7:0] sram_din = 8'hEE;

  int n_chk = 0, n_bad = 0;
  logic [7:0] pin_mem [256];
  logic [7:0] exp_mem [256];
  int last_done = 0;

  always #10 clk = ~clk;

  sram_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_setup(c_setup), .cfg_acc_addr(c_aa), .cfg_acc_cs(c_acs),
    .cfg_acc_oe(c_aoe), .cfg_release(c_rel), .cfg_we_width(c_we),
    .cfg_data_setup(c_ds), .cfg_data_hold(c_hold), .cfg_cycle_min(c_cmin),
    .done(done), .rdata(rdata), .sram_addr(sram_addr), .sram_dout(sram_dout),
    .sram_din(sram_din), .sram_dout_en(dout_en), .sram_cs_n(cs_n),
    .sram_oe_n(oe_n), .sram_we_n(we_n));

  // {write nibble, addr, wdata, setup, t_addr, t_cs, t_oe, release, we_width, data_setup, hold, cycle_min}
  localparam logic [55:0] VEC [0:9] = '{
    56'h1_05_C3_2_0_0_0_0_3_2_1_0,
    56'h0_05_00_1_5_2_1_2_0_0_0_0,
    56'h0_05_00_0_0_6_1_1_0_0_0_0,
    56'h0_30_00_2_3_2_4_3_0_0_0_0,
    56'h1_0A_5F_0_0_0_0_0_0_0_0_0,
    56'h1_0B_96_1_0_0_0_0_1_4_3_F,
    56'h0_0A_00_0_0_0_0_0_0_0_0_C,
    56'h0_0B_00_3_F_0_2_0_0_0_0_0,
    56'h1_05_3C_3_0_0_0_0_5_1_2_0,
    56'h0_05_00_1_1_1_3_1_0_0_0_2
  };

  function automatic int n1(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [55:0] v, input int idx);
    logic w;
    logic [7:0] a, wd, prev_rdata;
    int s, k, off, don, doff, t, cs_run, oe_run;
    int fcs, rcs, fst, rst_i, fd, rd, tdone, addr_bad, ready_bad;
    logic prev_we;
    w = v[52];  a = v[51:44];  wd = v[43:36];
    s = n1(v[35:32]);
    if (w) begin
      k = imax(n1(v[15:12]), n1(v[11:8]));
      off = s + k;  don = off - n1(v[11:8]);  doff = off + n1(v[7:4]);
      t = imax(doff, n1(v[3:0]));
    end else begin
      k = imax(imax(n1(v[23:20]), n1(v[27:24]) - 1), n1(v[31:28]) - s - 1);
      off = s + 1 + k;  don = -1;  doff = -1;
      t = imax(off + n1(v[19:16]), n1(v[3:0]));
    end
    prev_rdata = rdata;
    req_valid = 1'b1;  req_write = w;  req_addr = a;  req_wdata = wd;
    {c_setup, c_aa, c_acs, c_aoe, c_rel, c_we, c_ds, c_hold, c_cmin} = v[35:0];
    fcs = -1; rcs = -1; fst = -1; rst_i = -1; fd = -1; rd = -1; tdone = -1;
    addr_bad = 0; ready_bad = 0; cs_run = 0; oe_run = 0; prev_we = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_addr = ~a;  req_wdata = ~wd;  req_write = ~w;
        {c_setup, c_aa, c_acs, c_aoe, c_rel, c_we, c_ds, c_hold, c_cmin} = '1;
      end
      if (i == 1) req_valid = 1'b0;
      cs_run = cs_n ? 0 : cs_run + 1;
      oe_run = oe_n ? 0 : oe_run + 1;
      if (!cs_n && fcs < 0) fcs = i;
      if (cs_n && fcs >= 0 && rcs < 0) rcs = i;
      if (!(w ? we_n : oe_n) && fst < 0) fst = i;
      if ((w ? we_n : oe_n) && fst >= 0 && rst_i < 0) rst_i = i;
      if (dout_en && fd < 0) fd = i;
      if (!dout_en && fd >= 0 && rd < 0) rd = i;
      if (dout_en && sram_dout != wd) addr_bad++;
      if (sram_addr != a) addr_bad++;
      if (!prev_we && we_n && dout_en) pin_mem[sram_addr] = sram_dout;
      prev_we = we_n;
      sram_din = (!cs_n && !oe_n && oe_run >= n1(v[23:20]) && cs_run >= n1(v[27:24])
                  && i + 1 >= n1(v[31:28])) ? pin_mem[sram_addr] : 8'hEE;
      if (done) begin
        tdone = i;
        if (!req_ready) ready_bad++;
        break;
      end
      if (req_ready) ready_bad++;
    end
    if (tdone < 0) begin
      $display("FAIL R10 vector %0d: no done within 120 cycles", idx);
      n_bad++;  n_chk++;
    end
    last_done = tdone;
    if (w) begin
      exp_mem[a] = wd;
      chk("R6", "cs_n fall", fcs, 0);
      chk("R6", "we_n fall", fst, s);
      chk("R7", "we_n rise", rst_i, off);
      chk("R7", "cs_n rise", rcs, off);
      chk("R8", "dout_en rise", fd, don);
      chk("R9", "dout_en fall", rd, doff);
      chk("R13", "rdata kept on write", int'(rdata), int'(prev_rdata));
    end else begin
      chk("R3", "cs_n fall", fcs, s);
      chk("R3", "oe_n fall", fst, s + 1);
      chk("R4", "oe_n rise", rst_i, off);
      chk("R4", "cs_n rise", rcs, off);
      chk("R12", "dout_en in read", fd, -1);
      chk("R4", "read data", int'(rdata), int'(exp_mem[a]));
    end
    chk(w ? "R10" : "R5", "done cycle", tdone, t);
    chk("R2", "address/data hold faults", addr_bad, 0);
    chk("R2", "ready faults", ready_bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;  n_chk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      pin_mem[i] = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    // R1: state right after reset
    chk("R1", "strobes high", int'({cs_n, oe_n, we_n}), 7);
    chk("R1", "dout_en/done low", int'({dout_en, done}), 0);
    chk("R1", "ready high", int'(req_ready), 1);
    rst = 1'b0;
    // R2: no request, no activity
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2", "idle strobes", int'({cs_n, oe_n, we_n, dout_en, done}), 5'b11100);
    end
    for (int n = 0; n < 10; n++) begin
      run_vec(VEC[n], n);
      if (n == 4) chk("R11", "zero-count write done cycle", last_done, 3);
      if (n == 6) chk("R11", "zero-count read padded done cycle", last_done, 12);
    end
    // R1: reset while the write strobe is low
    req_valid = 1'b1;  req_write = 1'b1;  req_addr = 8'h44;  req_wdata = 8'h11;
    {c_setup, c_aa, c_acs, c_aoe, c_rel, c_we, c_ds, c_hold, c_cmin} = 36'h1_0_0_0_0_6_2_2_0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1", "we_n low before reset", int'(we_n), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "strobes high after mid-cycle reset", int'({cs_n, oe_n, we_n}), 7);
    chk("R1", "dout_en low after mid-cycle reset", int'(dout_en), 0);
    chk("R1", "ready after mid-cycle reset", int'(req_ready), 1);
    run_vec(56'h0_05_00_1_1_1_1_1_0_0_0_0, 10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule